// File: doc/BRIEF.md
# Fault Status Capture Register Bank

This block records the status word and faulting address of an abort. It sits after the abort router, which has already decided whether the event goes to the monitor. On each write strobe it picks one of two banks (secure or non-secure) and one of two sides (instruction or data). It builds a status word in either the long-descriptor or the short-descriptor layout and stores it with the faulting address.

The layout is chosen separately for each event. It depends on the extended-address-enable bit of each bank, the security state, whether the abort came from the hypervisor level and, on the data side only, whether the event is an asynchronous error. A data-side abort raised by an instruction-cache maintenance operation also rewrites the instruction-side status register of the same bank. In the short layout, with the reporting option enabled, that register gets a dedicated maintenance code. In every other case it is cleared. The fault type arrives as a 3-bit kind and is mapped through a small built-in table.

Top module: `fault_status_bank`

## Requirements
- R1: After reset all eight registers read zero.
- R2: While `wr_en` is low no register changes, whatever the other inputs do.
- R3: An event with `to_monitor` high writes only the secure bank (`*_s`). An event with `to_monitor` low writes only the non-secure bank (`*_ns`).
- R4: A data event (`is_data`=1) writes the data status and data address of the selected bank. An instruction event writes the instruction status and instruction address. The whole `fault_addr` is captured, and the result is visible from the cycle after the strobe edge.
- R5: When `to_monitor` is low, or `is_secure` is high, the long layout is used exactly when the enable bit of the current bank is set: `sec_lpae` if `is_secure`, else `ns_lpae`.
- R6: For a data event with `to_monitor` high and `is_secure` low, the long layout is used if `sec_lpae` is set. Otherwise it is used only if `is_async` is low and either `from_hyp` or `ns_lpae` is set.
- R7: For an instruction event with `to_monitor` high and `is_secure` low, the long layout is used if any of `sec_lpae`, `from_hyp` or `ns_lpae` is set.
- R8: The long layout has bit 9 set and the 6-bit long code in bits 5:0. The short layout has bit 9 clear, bit 4 of the 5-bit short code in bit 10, and the code's bits 3:0 in bits 3:0. Bit 11 is `is_write` on data events and 0 on instruction events. All other bits are zero.
- R9: The `kind` codes 0..7 map to long codes 0x21, 0x05, 0x09, 0x3D, 0x0D, 0x10, 0x11, 0x22 and to short codes 0x01, 0x05, 0x03, 0x09, 0x0D, 0x08, 0x16, 0x02.
- R10: A data event with `is_icmaint` high also writes the instruction status of the same bank. With the short layout and `ICM_REPORT`=1 it gets the data status word with bit 10 cleared and bits 3:0 set to 4. Otherwise it gets zero. The instruction address is left unchanged.
- R11: `is_icmaint` has no effect on instruction events.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Capture strobe, one event per cycle |
| is_data | input | 1 | 1 = data abort, 0 = instruction abort |
| to_monitor | input | 1 | Router sent the abort to the monitor |
| is_secure | input | 1 | Core is in secure state |
| from_hyp | input | 1 | Abort taken from the hypervisor level |
| is_async | input | 1 | Abort is an asynchronous error |
| is_icmaint | input | 1 | Access was an instruction-cache maintenance operation |
| is_write | input | 1 | Access was a write |
| kind | input | 3 | Fault type index |
| fault_addr | input | AW | Faulting virtual address |
| sec_lpae | input | 1 | Extended-address-enable bit of the secure bank |
| ns_lpae | input | 1 | Extended-address-enable bit of the non-secure bank |
| dstat_ns | output | SW | Non-secure data status |
| daddr_ns | output | AW | Non-secure data address |
| istat_ns | output | SW | Non-secure instruction status |
| iaddr_ns | output | AW | Non-secure instruction address |
| dstat_s | output | SW | Secure data status |
| daddr_s | output | AW | Secure data address |
| istat_s | output | SW | Secure instruction status |
| iaddr_s | output | AW | Secure instruction address |

## Verification
The bench builds two copies with SW=32 and AW=32, one with `ICM_REPORT`=1 and one with `ICM_REPORT`=0, so both branches of the maintenance rule are exercised. It sweeps every combination of the nine control bits and all eight fault kinds, which covers every case of the layout selection on both sides. After each write it runs an idle cycle with changed inputs to show the strobe gates the registers.

// File: rtl/fsc_pkg.sv
// Package: shared fault-kind type, status word bit positions and code tables.
// Assumes status words are at least 12 bits wide.
package fsc_pkg;
    typedef enum logic [2:0] {
        FK_ALIGN  = 3'd0,
        FK_XLATE  = 3'd1,
        FK_ACCESS = 3'd2,
        FK_DOMAIN = 3'd3,
        FK_PERM   = 3'd4,
        FK_EXTSYN = 3'd5,
        FK_ASYNC  = 3'd6,
        FK_DEBUG  = 3'd7
    } fault_kind_e;

    localparam int          FMT_BIT  = 9;
    localparam int          WNR_BIT  = 11;
    localparam int          SHI_BIT  = 10;
    localparam logic [4:0]  ICM_CODE = 5'h04;

    // Long-layout fault code for a kind
    function automatic logic [5:0] long_code(input fault_kind_e k);
        case (k)
            FK_ALIGN:  return 6'h21;
            FK_XLATE:  return 6'h05;
            FK_ACCESS: return 6'h09;
            FK_DOMAIN: return 6'h3D;
            FK_PERM:   return 6'h0D;
            FK_EXTSYN: return 6'h10;
            FK_ASYNC:  return 6'h11;
            default:   return 6'h22;
        endcase
    endfunction

    // Short-layout fault code for a kind
    function automatic logic [4:0] short_code(input fault_kind_e k);
        case (k)
            FK_ALIGN:  return 5'h01;
            FK_XLATE:  return 5'h05;
            FK_ACCESS: return 5'h03;
            FK_DOMAIN: return 5'h09;
            FK_PERM:   return 5'h0D;
            FK_EXTSYN: return 5'h08;
            FK_ASYNC:  return 5'h16;
            default:   return 5'h02;
        endcase
    endfunction
endpackage

// File: rtl/fsc_format_sel.sv
// Module: decides long or short status layout for one event.
// Assumes the router's monitor decision is final; purely combinational.
module fsc_format_sel (
    input  logic is_data,
    input  logic to_monitor,
    input  logic is_secure,
    input  logic from_hyp,
    input  logic is_async,
    input  logic sec_lpae,
    input  logic ns_lpae,
    output logic use_long
);
    // Layout choice from the banked enable bits and the event attributes
    always_comb begin
        if (to_monitor && !is_secure) begin
            if (is_data)
                use_long = sec_lpae | (!is_async & (from_hyp | ns_lpae));
            else
                use_long = sec_lpae | from_hyp | ns_lpae;
        end else begin
            use_long = is_secure ? sec_lpae : ns_lpae;
        end
    end
endmodule

// File: rtl/fsc_encode.sv
// Module: builds the status word and the maintenance-side word.
// Assumes SW >= 12; an unknown value is produced as zero.
module fsc_encode
    import fsc_pkg::*;
#(
    parameter int SW         = 32,
    parameter bit ICM_REPORT = 1'b1
) (
    input  fault_kind_e     kind,
    input  logic            use_long,
    input  logic            wnr,
    output logic [SW-1:0]   syn,
    output logic [SW-1:0]   icm_syn
);
    logic [5:0] lc;
    logic [4:0] sc;

    assign lc = long_code(kind);
    assign sc = short_code(kind);

    // Main status word in the chosen layout
    always_comb begin
        syn = '0;
        if (use_long) begin
            syn[FMT_BIT] = 1'b1;
            syn[5:0]     = lc;
        end else begin
            syn[SHI_BIT] = sc[4];
            syn[3:0]     = sc[3:0];
        end
        syn[WNR_BIT] = wnr;
    end

    // Instruction-side word for a maintenance fault, zero where unknown
    always_comb begin
        icm_syn = '0;
        if (!use_long && ICM_REPORT) begin
            icm_syn          = syn;
            icm_syn[SHI_BIT] = ICM_CODE[4];
            icm_syn[3:0]     = ICM_CODE[3:0];
        end
    end
endmodule

// File: rtl/fsc_bank.sv
// Module: one bank of four registers (data/instruction status and address).
// Assumes at most one capture per cycle; synchronous active-low reset.
module fsc_bank #(
    parameter int SW = 32,
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic          is_data,
    input  logic          icm,
    input  logic [SW-1:0] syn,
    input  logic [SW-1:0] icm_syn,
    input  logic [AW-1:0] addr,
    output logic [SW-1:0] dstat,
    output logic [AW-1:0] daddr,
    output logic [SW-1:0] istat,
    output logic [AW-1:0] iaddr
);
    // Capture status and address into the side named by the event
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dstat <= '0;
            daddr <= '0;
            istat <= '0;
            iaddr <= '0;
        end else if (we) begin
            if (is_data) begin
                dstat <= syn;
                daddr <= addr;
                if (icm) istat <= icm_syn;
            end else begin
                istat <= syn;
                iaddr <= addr;
            end
        end
    end
endmodule

// File: rtl/fault_status_bank.sv
// Module: top of the fault status capture bank; two banks, selected by the
// monitor decision. Assumes inputs are stable around the strobe edge.
module fault_status_bank
    import fsc_pkg::*;
#(
    parameter int SW         = 32,
    parameter int AW         = 32,
    parameter bit ICM_REPORT = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic          is_data,
    input  logic          to_monitor,
    input  logic          is_secure,
    input  logic          from_hyp,
    input  logic          is_async,
    input  logic          is_icmaint,
    input  logic          is_write,
    input  logic [2:0]    kind,
    input  logic [AW-1:0] fault_addr,
    input  logic          sec_lpae,
    input  logic          ns_lpae,
    output logic [SW-1:0] dstat_ns,
    output logic [AW-1:0] daddr_ns,
    output logic [SW-1:0] istat_ns,
    output logic [AW-1:0] iaddr_ns,
    output logic [SW-1:0] dstat_s,
    output logic [AW-1:0] daddr_s,
    output logic [SW-1:0] istat_s,
    output logic [AW-1:0] iaddr_s
);
    localparam int NBANK = 2;

    logic          use_long;
    logic [SW-1:0] syn;
    logic [SW-1:0] icm_syn;
    logic [SW-1:0] bk_dstat [NBANK];
    logic [AW-1:0] bk_daddr [NBANK];
    logic [SW-1:0] bk_istat [NBANK];
    logic [AW-1:0] bk_iaddr [NBANK];

    fsc_format_sel u_fmt (
        .is_data    (is_data),
        .to_monitor (to_monitor),
        .is_secure  (is_secure),
        .from_hyp   (from_hyp),
        .is_async   (is_async),
        .sec_lpae   (sec_lpae),
        .ns_lpae    (ns_lpae),
        .use_long   (use_long)
    );

    fsc_encode #(.SW(SW), .ICM_REPORT(ICM_REPORT)) u_enc (
        .kind     (fault_kind_e'(kind)),
        .use_long (use_long),
        .wnr      (is_data & is_write),
        .syn      (syn),
        .icm_syn  (icm_syn)
    );

    // Bank 0 is non-secure, bank 1 is secure (monitor-routed)
    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        fsc_bank #(.SW(SW), .AW(AW)) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .we      (wr_en && (to_monitor == (b == 1))),
            .is_data (is_data),
            .icm     (is_icmaint),
            .syn     (syn),
            .icm_syn (icm_syn),
            .addr    (fault_addr),
            .dstat   (bk_dstat[b]),
            .daddr   (bk_daddr[b]),
            .istat   (bk_istat[b]),
            .iaddr   (bk_iaddr[b])
        );
    end

    assign dstat_ns = bk_dstat[0];
    assign daddr_ns = bk_daddr[0];
    assign istat_ns = bk_istat[0];
    assign iaddr_ns = bk_iaddr[0];
    assign dstat_s  = bk_dstat[1];
    assign daddr_s  = bk_daddr[1];
    assign istat_s  = bk_istat[1];
    assign iaddr_s  = bk_iaddr[1];
endmodule

// File: rtl/fsc_checker.sv
// Module: assertion checker bound to fault_status_bank; observes ports only.
module fsc_checker #(
    parameter int SW = 32,
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          wr_en,
    input logic          is_data,
    input logic          to_monitor,
    input logic          is_secure,
    input logic          from_hyp,
    input logic          is_async,
    input logic          is_icmaint,
    input logic          is_write,
    input logic [2:0]    kind,
    input logic [AW-1:0] fault_addr,
    input logic          sec_lpae,
    input logic          ns_lpae,
    input logic [SW-1:0] dstat_ns,
    input logic [AW-1:0] daddr_ns,
    input logic [SW-1:0] istat_ns,
    input logic [AW-1:0] iaddr_ns,
    input logic [SW-1:0] dstat_s,
    input logic [AW-1:0] daddr_s,
    input logic [SW-1:0] istat_s,
    input logic [AW-1:0] iaddr_s
);
    a_r2_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(dstat_ns) && $stable(daddr_ns) && $stable(istat_ns)
                   && $stable(iaddr_ns) && $stable(dstat_s) && $stable(daddr_s)
                   && $stable(istat_s) && $stable(iaddr_s));

    a_r3_ns_untouched: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && to_monitor |=> $stable(dstat_ns) && $stable(daddr_ns)
                                && $stable(istat_ns) && $stable(iaddr_ns));

    a_r3_s_untouched: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && !to_monitor |=> $stable(dstat_s) && $stable(daddr_s)
                                 && $stable(istat_s) && $stable(iaddr_s));

    a_r4_iaddr_capture: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && !is_data && to_monitor |=> iaddr_s == $past(fault_addr));

    a_r4_data_side_only: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && !is_data |=> $stable(dstat_ns) && $stable(daddr_ns)
                              && $stable(dstat_s) && $stable(daddr_s));

    a_r6_async_short: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && is_data && to_monitor && !is_secure && !sec_lpae && is_async
        |=> !dstat_s[9]);

    a_r7_hyp_long: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && !is_data && to_monitor && !is_secure && from_hyp |=> istat_s[9]);

    a_r8_no_write_bit: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && is_data && !is_write && !to_monitor |=> !dstat_ns[11]);

    a_r9_align_short: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && !is_data && !to_monitor && !is_secure && !ns_lpae && kind == 3'd0
        |=> istat_ns[3:0] == 4'h1 && !istat_ns[10]);

    a_r10_iaddr_kept: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && is_data && is_icmaint |=> $stable(iaddr_ns) && $stable(iaddr_s));

    a_r10_istat_kept: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && is_data && !is_icmaint |=> $stable(istat_ns) && $stable(istat_s));
endmodule

bind fault_status_bank fsc_checker #(.SW(SW), .AW(AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .is_data(is_data),
    .to_monitor(to_monitor), .is_secure(is_secure), .from_hyp(from_hyp),
    .is_async(is_async), .is_icmaint(is_icmaint), .is_write(is_write),
    .kind(kind), .fault_addr(fault_addr), .sec_lpae(sec_lpae), .ns_lpae(ns_lpae),
    .dstat_ns(dstat_ns), .daddr_ns(daddr_ns), .istat_ns(istat_ns), .iaddr_ns(iaddr_ns),
    .dstat_s(dstat_s), .daddr_s(daddr_s), .istat_s(istat_s), .iaddr_s(iaddr_s)
);

// File: tb/fault_status_bank_tb.sv
module fault_status_bank_tb;
    localparam int CLK_PERIOD = 10;
    localparam int SW = 32;
    localparam int AW = 32;
    localparam int WATCHDOG = 150000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0, is_data = 1'b0, to_monitor = 1'b0, is_secure = 1'b0;
    logic from_hyp = 1'b0, is_async = 1'b0, is_icmaint = 1'b0, is_write = 1'b0;
    logic [2:0] kind = '0;
    logic [AW-1:0] fault_addr = '0;
    logic sec_lpae = 1'b0, ns_lpae = 1'b0;

    logic [SW-1:0] a_dns, a_ins, a_ds, a_is, b_dns, b_ins, b_ds, b_is;
    logic [AW-1:0] a_dans, a_ians, a_das, a_ias, b_dans, b_ians, b_das, b_ias;

    // Reference state: index [0]=ns data stat,[1]=ns data addr,[2]=ns inst stat,
    // [3]=ns inst addr,[4..7]=same for secure; model A has ICM_REPORT=1, B has 0
    logic [31:0] ma [8];
    logic [31:0] mb [8];

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fault_status_bank #(.SW(SW), .AW(AW), .ICM_REPORT(1'b1)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .is_data(is_data),
        .to_monitor(to_monitor), .is_secure(is_secure), .from_hyp(from_hyp),
        .is_async(is_async), .is_icmaint(is_icmaint), .is_write(is_write),
        .kind(kind), .fault_addr(fault_addr), .sec_lpae(sec_lpae), .ns_lpae(ns_lpae),
        .dstat_ns(a_dns), .daddr_ns(a_dans), .istat_ns(a_ins), .iaddr_ns(a_ians),
        .dstat_s(a_ds), .daddr_s(a_das), .istat_s(a_is), .iaddr_s(a_ias));

    fault_status_bank #(.SW(SW), .AW(AW), .ICM_REPORT(1'b0)) u_dut_b (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .is_data(is_data),
        .to_monitor(to_monitor), .is_secure(is_secure), .from_hyp(from_hyp),
        .is_async(is_async), .is_icmaint(is_icmaint), .is_write(is_write),
        .kind(kind), .fault_addr(fault_addr), .sec_lpae(sec_lpae), .ns_lpae(ns_lpae),
        .dstat_ns(b_dns), .daddr_ns(b_dans), .istat_ns(b_ins), .iaddr_ns(b_ians),
        .dstat_s(b_ds), .daddr_s(b_das), .istat_s(b_is), .iaddr_s(b_ias));

    // R9 code tables
    function automatic int lcode(input int k);
        case (k)
            0: return 'h21; 1: return 'h05; 2: return 'h09; 3: return 'h3D;
            4: return 'h0D; 5: return 'h10; 6: return 'h11; default: return 'h22;
        endcase
    endfunction
    function automatic int scode(input int k);
        case (k)
            0: return 'h01; 1: return 'h05; 2: return 'h03; 3: return 'h09;
            4: return 'h0D; 5: return 'h08; 6: return 'h16; default: return 'h02;
        endcase
    endfunction

    // R5, R6, R7 layout rules
    function automatic bit exp_long(input bit d, mon, sec, hyp, asy, sl, nl);
        if (mon && !sec) begin
            if (d) return sl || (!asy && (hyp || nl));
            return sl || hyp || nl;
        end
        return sec ? sl : nl;
    endfunction

    // R8 layout of the status word
    function automatic logic [31:0] exp_word(input int k, input bit lng, input bit wnr);
        logic [31:0] w;
        if (lng) w = 32'(512 + lcode(k));
        else     w = 32'(((scode(k) / 16) * 1024) + (scode(k) % 16));
        return w + (wnr ? 32'd2048 : 32'd0);
    endfunction

    task automatic cmp(input string req, input int idx, input logic [31:0] act,
                       input logic [31:0] exp, input string who);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s reg%0d: actual %h expected %h", req, who, idx, act, exp);
        end
    endtask

    task automatic check_all(input string req);
        cmp(req, 0, a_dns, ma[0], "A"); cmp(req, 1, a_dans, ma[1], "A");
        cmp(req, 2, a_ins, ma[2], "A"); cmp(req, 3, a_ians, ma[3], "A");
        cmp(req, 4, a_ds,  ma[4], "A"); cmp(req, 5, a_das,  ma[5], "A");
        cmp(req, 6, a_is,  ma[6], "A"); cmp(req, 7, a_ias,  ma[7], "A");
        cmp(req, 0, b_dns, mb[0], "B"); cmp(req, 1, b_dans, mb[1], "B");
        cmp(req, 2, b_ins, mb[2], "B"); cmp(req, 3, b_ians, mb[3], "B");
        cmp(req, 4, b_ds,  mb[4], "B"); cmp(req, 5, b_das,  mb[5], "B");
        cmp(req, 6, b_is,  mb[6], "B"); cmp(req, 7, b_ias,  mb[7], "B");
    endtask

    // Watchdog: an expired run is a failed check and still prints the summary
    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected below %0d", cycles, WATCHDOG);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int j = 0; j < 8; j++) begin ma[j] = '0; mb[j] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R1");

        for (int i = 0; i < 4096; i++) begin
            bit d, mon, sec, hyp, asy, icm, wr, sl, nl, lng;
            int k, base;
            logic [31:0] w, wi;
            d = i[0]; mon = i[1]; sec = i[2]; hyp = i[3]; asy = i[4];
            icm = i[5]; wr = i[6]; sl = i[7]; nl = i[8]; k = i / 512;
            lng = exp_long(d, mon, sec, hyp, asy, sl, nl);
            w = exp_word(k, lng, d && wr);
            is_data = d; to_monitor = mon; is_secure = sec; from_hyp = hyp;
            is_async = asy; is_icmaint = icm; is_write = wr; kind = 3'(k);
            sec_lpae = sl; ns_lpae = nl;
            fault_addr = 32'(i + 1) * 32'h9E3779B9;
            wr_en = 1'b1;
            base = mon ? 4 : 0;                       // R3 bank choice
            if (d) begin                              // R4 data side
                ma[base] = w; ma[base+1] = fault_addr;
                mb[base] = w; mb[base+1] = fault_addr;
                if (icm) begin                        // R10 maintenance rewrite
                    wi = (w & ~32'h0000_040F) | 32'h4;
                    ma[base+2] = lng ? 32'h0 : wi;
                    mb[base+2] = 32'h0;
                end
            end else begin                            // R4, R11 instruction side
                ma[base+2] = w; ma[base+3] = fault_addr;
                mb[base+2] = w; mb[base+3] = fault_addr;
            end
            @(negedge clk);
            if (!d && icm) check_all("R11");
            else if (d && icm) check_all("R10");
            else if (mon && !sec) check_all(d ? "R6" : "R7");
            else check_all("R5_R8_R9");
            // R2: idle cycle with changed inputs
            wr_en = 1'b0;
            to_monitor = ~mon; is_data = ~d; fault_addr = ~fault_addr;
            @(negedge clk);
            check_all("R2");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule